// File: doc/BRIEF.md
# Root Port Interrupt Mode Selector

This block turns three root-port event sources into interrupts. The sources are hot-plug (index 0), power-management event (index 1) and error reporting (index 2). Each source has its own status bit and enable bit. From the two message enable bits the block picks one signalling mode for the whole port. In legacy mode it drives a level INTx output. In single-vector message mode (MSI) or multi-vector message mode (MSI-X) it drives a valid/ready message request that carries a vector number. The block never splits sources between the two kinds of signalling.

In message mode, each source forms a combined condition: status set, enable set and its vector not masked. Every false-to-true transition of that condition queues one message. The block keeps one pending flag per source. A repeat transition that arrives while the flag is still set is merged with it. A static option can force legacy signalling for every source. The same happens when a parameter marks any source as unable to use messages.

Top module: `rc_irq_select`

## Requirements
- R1: After reset, `intx_out` and `msg_valid` are both low.
- R2: In legacy mode (both message enables clear, or messages not permitted), `intx_out` is high one cycle after any source has both status and enable set, and low one cycle after no source does.
- R3: While `intx_disable` is high, `intx_out` is low one cycle later, whatever the statuses are.
- R4: In a message mode, each false-to-true transition of a source's combined condition (status AND enable AND unmasked) produces exactly one accepted message. A condition that stays true produces no further messages.
- R5: A masked vector blocks messages. Clearing the mask while status and enable stay set produces one message. In MSI mode the single mask is `vec_mask[0]`. In MSI-X mode, source i uses `vec_mask[i]`.
- R6: With `msi_enable`=1 and `msix_enable`=0, every message carries vector 0 and `intx_out` stays low.
- R7: With `msix_enable`=1 and `msi_enable`=0, source i sends vector i and `intx_out` stays low.
- R8: With both message enables set (and messages permitted), no message is raised and `intx_out` stays low.
- R9: A raised request keeps `msg_valid` high with a stable `msg_vector` until `msg_ready` accepts it. A change of signalling mode withdraws the request.
- R10: Further transitions of a source whose message is still pending are merged into that one message.
- R11: When several sources are pending, they are issued in order of lowest source index first.
- R12: With `MSI_MASK_CAP`=0, the MSI mask bit is ignored and only status and enable form the condition.
- R13: With `FORCE_INTX`=1, or any source lacking message capability, the port uses legacy signalling even when a message enable is set, and it never raises a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_status | input | N_SRC | Per-source event status (0 hot-plug, 1 PME, 2 error) |
| src_enable | input | N_SRC | Per-source interrupt enable |
| msi_enable | input | 1 | Single-vector message enable |
| msix_enable | input | 1 | Multi-vector message enable |
| vec_mask | input | N_SRC | Vector mask per source; bit 0 also serves as the MSI mask |
| intx_disable | input | 1 | Legacy interrupt disable |
| msg_ready | input | 1 | Consumer accepts the message request |
| intx_out | output | 1 | Legacy level interrupt |
| msg_valid | output | 1 | Message request valid |
| msg_vector | output | clog2(N_VEC) | Vector number of the request |

## Verification
Each of the two internal states has its own visible symptom. A wrong edge-history register shows up two cycles after a status change: as a missing or duplicated accepted message, or as a message that follows an unmask or a mode entry when none should. A wrong pending flag shows up as an extra or lost message, or as the wrong issue order, once ready is released after a stall. A wrong mode decode shows up one cycle later as `intx_out` high during message signalling, or as a message request in the invalid or forced-legacy configuration.

// File: rtl/rc_irq_pkg.sv
package rc_irq_pkg;

    typedef enum logic [1:0] {
        MODE_INTX = 2'd0,
        MODE_MSI  = 2'd1,
        MODE_MSIX = 2'd2,
        MODE_BAD  = 2'd3
    } irq_mode_e;

    // Port-wide signalling mode: a port either uses messages for all
    // sources or legacy wire for all sources.
    function automatic irq_mode_e pick_mode(input logic msi, input logic msix,
                                            input logic msg_allowed);
        if (!msg_allowed)      return MODE_INTX;
        else if (msi && msix)  return MODE_BAD;
        else if (msi)          return MODE_MSI;
        else if (msix)         return MODE_MSIX;
        else                   return MODE_INTX;
    endfunction

    function automatic logic is_msg(input irq_mode_e m);
        return (m == MODE_MSI) || (m == MODE_MSIX);
    endfunction

endpackage

// File: rtl/rc_irq_mode_dec.sv
module rc_irq_mode_dec
    import rc_irq_pkg::*;
#(
    parameter int              N_SRC       = 3,
    parameter bit              FORCE_INTX  = 1'b0,
    parameter logic [N_SRC-1:0] SRC_MSG_CAP = '1
) (
    input  logic      msi_enable,
    input  logic      msix_enable,
    output irq_mode_e mode
);
    localparam bit MSG_ALLOWED = !FORCE_INTX && (&SRC_MSG_CAP);

    always_comb mode = pick_mode(msi_enable, msix_enable, MSG_ALLOWED);
endmodule

// File: rtl/rc_irq_edge.sv
module rc_irq_edge
    import rc_irq_pkg::*;
#(
    parameter int N_SRC        = 3,
    parameter bit MSI_MASK_CAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  irq_mode_e        mode,
    input  logic [N_SRC-1:0] src_status,
    input  logic [N_SRC-1:0] src_enable,
    input  logic [N_SRC-1:0] vec_mask,
    input  logic [N_SRC-1:0] take,
    output logic [N_SRC-1:0] pending,
    output logic             flush
);
    logic [N_SRC-1:0] cond;
    logic [N_SRC-1:0] cond_q;
    logic [N_SRC-1:0] pend_q;
    irq_mode_e        mode_q;

    // Any mode change or non-message mode drops history and queued work.
    assign flush = !is_msg(mode) || (mode != mode_q);

    for (genvar i = 0; i < N_SRC; i++) begin : g_cond
        logic unmasked;
        always_comb begin
            if (mode == MODE_MSI)
                unmasked = (MSI_MASK_CAP == 1'b0) || !vec_mask[0];
            else
                unmasked = !vec_mask[i];
            cond[i] = is_msg(mode) && src_status[i] && src_enable[i] && unmasked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            pend_q <= '0;
            mode_q <= MODE_INTX;
        end else begin
            mode_q <= mode;
            if (flush) begin
                cond_q <= '0;
                pend_q <= '0;
            end else begin
                cond_q <= cond;
                pend_q <= (pend_q & ~take) | (cond & ~cond_q);
            end
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/rc_irq_issue.sv
module rc_irq_issue
    import rc_irq_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int N_VEC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  irq_mode_e        mode,
    input  logic             flush,
    input  logic [N_SRC-1:0] pending,
    input  logic             msg_ready,
    output logic [N_SRC-1:0] take,
    output logic             msg_valid,
    output logic [((N_VEC > 1) ? $clog2(N_VEC) : 1)-1:0] msg_vector
);
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int VEC_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;

    logic [SRC_W-1:0] pick;
    logic             any_pend;
    logic             load;
    logic             out_v;
    logic [VEC_W-1:0] out_vec;

    always_comb begin
        pick = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) pick = SRC_W'(i);
        end
    end

    assign any_pend = |pending;
    assign load     = !out_v || msg_ready;
    assign take     = (load && !flush) ? ((N_SRC'(1) << pick) & pending) : '0;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            out_v   <= 1'b0;
            out_vec <= '0;
        end else if (load) begin
            out_v   <= any_pend;
            out_vec <= (mode == MODE_MSIX) ? VEC_W'(pick) : '0;
        end
    end

    assign msg_valid  = out_v;
    assign msg_vector = out_vec;
endmodule

// File: rtl/rc_irq_select.sv
module rc_irq_select
    import rc_irq_pkg::*;
#(
    parameter int               N_SRC        = 3,
    parameter int               N_VEC        = 8,
    parameter bit               MSI_MASK_CAP = 1'b1,
    parameter bit               FORCE_INTX   = 1'b0,
    parameter logic [N_SRC-1:0] SRC_MSG_CAP  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_status,
    input  logic [N_SRC-1:0] src_enable,
    input  logic             msi_enable,
    input  logic             msix_enable,
    input  logic [N_SRC-1:0] vec_mask,
    input  logic             intx_disable,
    input  logic             msg_ready,
    output logic             intx_out,
    output logic             msg_valid,
    output logic [((N_VEC > 1) ? $clog2(N_VEC) : 1)-1:0] msg_vector
);
    irq_mode_e        mode;
    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] take;
    logic             flush;
    logic             intx_q;

    rc_irq_mode_dec #(
        .N_SRC(N_SRC), .FORCE_INTX(FORCE_INTX), .SRC_MSG_CAP(SRC_MSG_CAP)
    ) u_dec (
        .msi_enable(msi_enable), .msix_enable(msix_enable), .mode(mode)
    );

    rc_irq_edge #(.N_SRC(N_SRC), .MSI_MASK_CAP(MSI_MASK_CAP)) u_edge (
        .clk(clk), .rst(rst), .mode(mode),
        .src_status(src_status), .src_enable(src_enable), .vec_mask(vec_mask),
        .take(take), .pending(pending), .flush(flush)
    );

    rc_irq_issue #(.N_SRC(N_SRC), .N_VEC(N_VEC)) u_issue (
        .clk(clk), .rst(rst), .mode(mode), .flush(flush),
        .pending(pending), .msg_ready(msg_ready), .take(take),
        .msg_valid(msg_valid), .msg_vector(msg_vector)
    );

    always_ff @(posedge clk) begin
        if (rst) intx_q <= 1'b0;
        else     intx_q <= (mode == MODE_INTX) && !intx_disable &&
                           (|(src_status & src_enable));
    end

    assign intx_out = intx_q;
endmodule

// File: rtl/rc_irq_select_chk.sv
module rc_irq_select_chk #(
    parameter int               N_SRC       = 3,
    parameter int               N_VEC       = 8,
    parameter bit               FORCE_INTX  = 1'b0,
    parameter logic [N_SRC-1:0] SRC_MSG_CAP = '1
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_status,
    input logic [N_SRC-1:0] src_enable,
    input logic             msi_enable,
    input logic             msix_enable,
    input logic             intx_disable,
    input logic             msg_ready,
    input logic             intx_out,
    input logic             msg_valid,
    input logic [((N_VEC > 1) ? $clog2(N_VEC) : 1)-1:0] msg_vector
);
    localparam bit ALLOW = !FORCE_INTX && (&SRC_MSG_CAP);

    logic legacy, msg_mode, msi_only, bad_cfg, any_evt;
    assign legacy   = !ALLOW || (!msi_enable && !msix_enable);
    assign msg_mode = ALLOW && (msi_enable ^ msix_enable);
    assign msi_only = ALLOW && msi_enable && !msix_enable;
    assign bad_cfg  = ALLOW && msi_enable && msix_enable;
    assign any_evt  = |(src_status & src_enable);

    a_r2_intx_follow: assert property (@(posedge clk) disable iff (rst)
        legacy && !intx_disable && any_evt |=> intx_out);

    a_r2_intx_idle: assert property (@(posedge clk) disable iff (rst)
        !any_evt |=> !intx_out);

    a_r3_intx_disabled: assert property (@(posedge clk) disable iff (rst)
        intx_disable |=> !intx_out);

    a_r6_no_intx_in_msg: assert property (@(posedge clk) disable iff (rst)
        msg_mode |=> !intx_out);

    a_r6_msi_vector_zero: assert property (@(posedge clk) disable iff (rst)
        msg_valid && $past(msi_only) |-> msg_vector == '0);

    a_r8_bad_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
        bad_cfg |=> !msg_valid && !intx_out);

    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready && msg_mode
        |=> !($stable(msi_enable) && $stable(msix_enable)) ||
            (msg_valid && $stable(msg_vector)));

    a_r13_forced_no_msg: assert property (@(posedge clk) disable iff (rst)
        !ALLOW |-> !msg_valid);
endmodule

bind rc_irq_select rc_irq_select_chk #(
    .N_SRC(N_SRC), .N_VEC(N_VEC), .FORCE_INTX(FORCE_INTX), .SRC_MSG_CAP(SRC_MSG_CAP)
) u_chk (
    .clk(clk), .rst(rst), .src_status(src_status), .src_enable(src_enable),
    .msi_enable(msi_enable), .msix_enable(msix_enable), .intx_disable(intx_disable),
    .msg_ready(msg_ready), .intx_out(intx_out), .msg_valid(msg_valid),
    .msg_vector(msg_vector)
);

// File: tb/rc_irq_select_tb.sv
module rc_irq_select_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 3;
    localparam int N_VEC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_SRC-1:0] st = '0, en = '0, mask = '0;
    logic msi = 1'b0, msix = 1'b0, dis = 1'b0, rdy = 1'b1;

    logic intx_m, v_m, intx_n, v_n, intx_f, v_f;
    logic [2:0] vec_m, vec_n, vec_f;

    int checks = 0, errors = 0;
    int cnt_m = 0, cnt_n = 0, cnt_f = 0;
    int exp_m = 0, exp_n = 0;
    int log_vec [0:63];
    int log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_irq_select #(.N_SRC(N_SRC), .N_VEC(N_VEC)) u_dut (
        .clk(clk), .rst(rst), .src_status(st), .src_enable(en),
        .msi_enable(msi), .msix_enable(msix), .vec_mask(mask),
        .intx_disable(dis), .msg_ready(rdy),
        .intx_out(intx_m), .msg_valid(v_m), .msg_vector(vec_m));

    rc_irq_select #(.N_SRC(N_SRC), .N_VEC(N_VEC), .MSI_MASK_CAP(1'b0)) u_nomask (
        .clk(clk), .rst(rst), .src_status(st), .src_enable(en),
        .msi_enable(msi), .msix_enable(msix), .vec_mask(mask),
        .intx_disable(dis), .msg_ready(rdy),
        .intx_out(intx_n), .msg_valid(v_n), .msg_vector(vec_n));

    rc_irq_select #(.N_SRC(N_SRC), .N_VEC(N_VEC), .FORCE_INTX(1'b1)) u_force (
        .clk(clk), .rst(rst), .src_status(st), .src_enable(en),
        .msi_enable(msi), .msix_enable(msix), .vec_mask(mask),
        .intx_disable(dis), .msg_ready(rdy),
        .intx_out(intx_f), .msg_valid(v_f), .msg_vector(vec_f));

    // Handshake monitor, sampled mid-cycle (inputs change just after posedge).
    always @(negedge clk) begin
        if (!rst) begin
            if (v_m && rdy) begin
                if (log_n < 64) log_vec[log_n] = int'(vec_m);
                log_n = log_n + 1;
                cnt_m = cnt_m + 1;
            end
            if (v_n && rdy) cnt_n = cnt_n + 1;
            if (v_f && rdy) cnt_f = cnt_f + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check("R1 intx after reset", int'(intx_m), 0);
        check("R1 valid after reset", int'(v_m), 0);

        // R2/R3 exhaustive legacy sweep
        for (int v = 0; v < 128; v++) begin
            st = v[2:0]; en = v[5:3]; dis = v[6];
            step(1);
            check(dis ? "R3 intx disable" : "R2 intx level", int'(intx_m),
                  int'(!dis && (|(st & en))));
            check(dis ? "R3 forced-inst disable" : "R2 forced-inst level", int'(intx_f),
                  int'(!dis && (|(st & en))));
        end
        check("R2 no messages in legacy mode", cnt_m, 0);

        // MSI mode
        st = '0; en = '1; dis = 1'b0; mask = '0; msi = 1'b1; rdy = 1'b1;
        step(4);
        st = 3'b010;
        step(6);
        exp_m++; exp_n++;
        check("R4 one message on PME edge", cnt_m, exp_m);
        check("R6 MSI vector 0", log_vec[log_n-1], 0);
        check("R6 no intx in MSI", int'(intx_m), 0);
        check("R13 forced instance uses intx", int'(intx_f), 1);
        step(10);
        check("R4 steady condition no repeat", cnt_m, exp_m);
        st = '0; step(3); st = 3'b010; step(6);
        exp_m++; exp_n++;
        check("R4 re-armed status new message", cnt_m, exp_m);

        st = '0; step(3); st = 3'b111; step(8);
        exp_m += 3; exp_n += 3;
        check("R6 three sources three messages", cnt_m, exp_m);
        check("R6 all vector 0", log_vec[log_n-1] + log_vec[log_n-2] + log_vec[log_n-3], 0);

        // R5 / R12 MSI mask
        st = '0; step(3); mask = 3'b001; st = 3'b001; step(6);
        exp_n++;
        check("R5 masked MSI blocks", cnt_m, exp_m);
        check("R12 mask ignored without mask capability", cnt_n, exp_n);
        mask = '0; step(6);
        exp_m++;
        check("R5 unmask sends one message", cnt_m, exp_m);
        check("R12 no extra message on unmask", cnt_n, exp_n);

        // R8 invalid configuration
        st = '0; msix = 1'b1; step(3); st = 3'b111; step(6);
        check("R8 both enables no message", cnt_m, exp_m);
        check("R8 both enables no intx", int'(intx_m), 0);
        check("R13 forced instance intx with enables", int'(intx_f), 1);

        // MSI-X mode
        st = '0; msi = 1'b0; step(4);
        st = 3'b100; step(6);
        exp_m++; exp_n++;
        check("R7 MSI-X message count", cnt_m, exp_m);
        check("R7 error source vector 2", log_vec[log_n-1], 2);
        check("R7 no intx in MSI-X", int'(intx_m), 0);
        st = '0; step(3); mask = 3'b010; st = 3'b010; step(6);
        check("R5 masked MSI-X vector blocks", cnt_m, exp_m);
        mask = '0; step(6);
        exp_m++; exp_n++;
        check("R5 unmask MSI-X sends", cnt_m, exp_m);
        check("R5 unmask MSI-X vector 1", log_vec[log_n-1], 1);

        // R9 / R10 / R11 stall, merge and order
        st = '0; step(3);
        rdy = 1'b0; st = 3'b101; step(3);
        check("R9 valid raised", int'(v_m), 1);
        check("R11 lowest index first", int'(vec_m), 0);
        step(3);
        check("R9 valid held", int'(v_m), 1);
        check("R9 vector held", int'(vec_m), 0);
        st = 3'b001; step(2); st = 3'b101; step(2);
        rdy = 1'b1; step(6);
        exp_m += 2; exp_n += 2;
        check("R10 repeat edge merged", cnt_m, exp_m);
        check("R11 order first", log_vec[log_n-2], 0);
        check("R11 order second", log_vec[log_n-1], 2);

        check("R12 nomask instance total", cnt_n, exp_n);
        check("R13 forced instance never messages", cnt_f, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule